// File: doc/BRIEF.md
# Inverting Shared-Bus Scratch RAM

This block is a small random-access store of sixteen four-bit words. It is meant to sit on a data bus that other blocks also drive. One active-low select and one active-low write strobe control it. A write saves the bitwise inverse of the data inputs into the addressed word. A later read presents that inverted value, so a word always reads back as the complement of what was written.

The bus side has two outputs: a data vector and a per-bit output enable. The enable is high only for a read, which is a selected chip with the write strobe released. It drops whenever the chip is deselected, the write strobe is low, or reset is held. Disabled data bits are driven to zero, so several copies can be combined into one shared bus.

Writes are synchronous and commit on the rising clock edge. The read path is purely combinational from the address. Word contents are not cleared by reset, so software must write a word before it reads that word.

Top module: `inv_bus_ram`

## Requirements
- R1: With the default parameters the store has 16 words of 4 bits. The 4-bit address decodes fully, so a write to one address leaves every other address unchanged.
- R2: A write commits only on a rising clock edge where cs_n is 0, we_n is 0 and rst_n is 1. A write strobe that rises again before the edge stores nothing.
- R3: The stored word is the bitwise inverse of din at the committing edge. A later read returns exactly that inverse.
- R4: While we_n is 0, every bit of dout_oe is 0, even when cs_n is 0.
- R5: While cs_n is 0, we_n is 1 and rst_n is 1, every bit of dout_oe is 1 and dout equals the stored word at addr. A change of addr shows on dout with no clock edge.
- R6: While cs_n is 1, dout_oe is all zero and no word is written, whatever we_n is.
- R7: While rst_n is 0, dout_oe is all zero and no write commits. Stored words survive a reset pulse.
- R8: Whenever an output-enable bit is 0, the matching dout bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes and disables outputs |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe; high means read |
| addr | input | ADDR_W (4) | Word address |
| din | input | DATA_W (4) | Write data; its inverse is stored |
| dout | output | DATA_W (4) | Read data; zero when not enabled |
| dout_oe | output | DATA_W (4) | Per-bit bus drive enable |

## Verification
The bench builds the block with its default ADDR_W of 4 and DATA_W of 4. That keeps the whole space small enough to cover completely. Every one of the 16 addresses is written and read back, and every one of the 16 data values is stored at a single address while a neighbouring word is watched for disturbance. The small size also makes it cheap to sweep all addresses again with the chip deselected, to strobe a write between two edges, and to pulse reset in the middle of a run. In each case the expected contents follow directly from the inversion rule.

// File: rtl/inv_ram_pkg.sv
package inv_ram_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_e;

endpackage

// File: rtl/inv_ram_ctrl.sv
module inv_ram_ctrl
    import inv_ram_pkg::*;
(
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    output acc_e mode
);

    always_comb begin
        mode = ACC_IDLE;
        if (rst_n && !cs_n) begin
            mode = we_n ? ACC_READ : ACC_WRITE;
        end
    end

endmodule

// File: rtl/inv_ram_decode.sv
module inv_ram_decode #(
    parameter int ADDR_W = 4,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORDS-1:0]  sel
);

    for (genvar g = 0; g < WORDS; g++) begin : g_line
        assign sel[g] = en && (addr == ADDR_W'(g));
    end

endmodule

// File: rtl/inv_ram_array.sv
module inv_ram_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [WORDS-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] words;
    } store_t;

    store_t store_d;
    store_t store_q;

    always_comb begin
        store_d = store_q;
        for (int w = 0; w < WORDS; w++) begin
            if (wr_sel[w]) begin
                store_d.words[w] = ~wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    assign rdata = store_q.words[rd_addr];

endmodule

// File: rtl/inv_ram_drive.sv
module inv_ram_drive
    import inv_ram_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  acc_e              mode,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dout_oe
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb begin
            dout_oe[b] = (mode == ACC_READ);
            dout[b]    = dout_oe[b] & rdata[b];
        end
    end

endmodule

// File: rtl/inv_bus_ram.sv
module inv_bus_ram
    import inv_ram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dout_oe
);

    acc_e              mode;
    logic [WORDS-1:0]  wr_sel;
    logic [DATA_W-1:0] rdata;

    inv_ram_ctrl u_ctrl (
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .we_n  (we_n),
        .mode  (mode)
    );

    inv_ram_decode #(.ADDR_W(ADDR_W)) u_dec (
        .en   (mode == ACC_WRITE),
        .addr (addr),
        .sel  (wr_sel)
    );

    inv_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .wr_sel  (wr_sel),
        .wdata   (din),
        .rd_addr (addr),
        .rdata   (rdata)
    );

    inv_ram_drive #(.DATA_W(DATA_W)) u_drv (
        .mode    (mode),
        .rdata   (rdata),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

endmodule

// File: rtl/inv_bus_ram_chk.sv
module inv_bus_ram_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int WORDS = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic [DATA_W-1:0] dout_oe,
    input logic [WORDS-1:0]  wr_sel
);

    // R1
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R3
    inv_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) ##1 (!cs_n && we_n && addr == $past(addr))
        |-> dout == ~$past(din));

    // R4
    hiz_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dout_oe == '0);

    // R5
    drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n) |-> dout_oe == '1);

    // R6
    hiz_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (dout_oe == '0 && wr_sel == '0));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout & ~dout_oe) == '0);

endmodule

bind inv_bus_ram inv_bus_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_oe (dout_oe),
    .wr_sel  (wr_sel)
);

// File: tb/sim_inv_bus_ram.sv
module sim_inv_bus_ram;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic       we_n;
    logic [3:0] addr;
    logic [3:0] din;
    logic [3:0] dout;
    logic [3:0] dout_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    inv_bus_ram u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    function automatic logic [3:0] pat(input int a);
        return 4'((a * 5 + 3) & 15);
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_off(input string req);
        check(req, dout_oe, 4'h0);
        check("R8", dout, 4'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_off("R7");
        cs_n = 1'b0; #1;
        check_off("R7");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R3 R4: write every address
        for (int a = 0; a < 16; a++) begin
            cs_n = 1'b0; we_n = 1'b0; addr = 4'(a); din = pat(a);
            #1;
            check_off("R4");
            @(negedge clk);
        end
        // R1 R3 R5: read every address combinationally
        we_n = 1'b1;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a); #1;
            check("R5", dout_oe, 4'hF);
            check("R3", dout, ~pat(a));
        end

        // R6: deselected writes do nothing
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            cs_n = 1'b1; we_n = 1'b0; addr = 4'(a); din = ~pat(a);
            #1;
            check_off("R6");
            @(negedge clk);
        end
        cs_n = 1'b0; we_n = 1'b1;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a); #1;
            check("R6", dout, ~pat(a));
        end

        // R3 R1: every data value at address 5, word 6 untouched
        @(negedge clk);
        for (int v = 0; v < 16; v++) begin
            we_n = 1'b0; addr = 4'd5; din = 4'(v);
            @(negedge clk);
            we_n = 1'b1; #1;
            check("R3", dout, ~4'(v));
            addr = 4'd6; #1;
            check("R1", dout, ~pat(6));
            @(negedge clk);
        end

        // R2: strobe released before the edge
        we_n = 1'b0; addr = 4'd9; din = 4'hA; #1;
        we_n = 1'b1; #1;
        @(negedge clk);
        check("R2", dout, ~pat(9));

        // R7: reset pulse blocks write and keeps contents
        rst_n = 1'b0; cs_n = 1'b0; we_n = 1'b0; addr = 4'd3; din = 4'h7;
        @(negedge clk);
        check_off("R7");
        rst_n = 1'b1; we_n = 1'b1; #1;
        check("R7", dout, ~pat(3));
        check("R5", dout_oe, 4'hF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule